// File: doc/BRIEF.md
# Rail Voltage Emergency Vulnerability Monitor

This block scores how exposed one run of a procedure is to fast supply-noise events. On each clock cycle it receives a burst of digitized rail-deviation magnitudes taken at sub-cycle rate. One burst covers the positive rail's droop and one covers the ground rail's rise. Any cycle whose burst holds a sample above a limit is marked as an emergency cycle. The limit is a fixed percentage of the nominal supply code.

Between a window-open pulse and a window-close pulse the block counts valid cycles and emergency cycles. After the window closes it divides the two counts with a bit-serial divider, which gives an unsigned Q0.16 vulnerability fraction. It then compares the exact quotient against a programmable Q0.16 threshold. The result is a single decision bit: stay on this core (0) or move the procedure elsewhere (1). A one-cycle done pulse marks when ratio and decision are valid.

Top module: `rail_vuln_monitor`

## Requirements
- R1: A valid cycle is an emergency cycle when at least one of its SAMPLES droop samples or SAMPLES rise samples is strictly greater than the limit. A sample equal to the limit does not count. Sample k of each rail sits at bits [k*SAMPLE_W +: SAMPLE_W].
- R2: The limit is floor(nom_code * LIMIT_PCT / 100) (LIMIT_PCT defaults to 4). It is captured on the cycle the window opens and ignores later changes of nom_code until the next window.
- R3: Opening a window clears both counts. Each cycle in the open window with smp_vld high adds one to total_cnt and, if it is an emergency cycle, one to emerg_cnt. Cycles with smp_vld low change neither count.
- R4: Both counts stop at 2^CNT_W-1 and never wrap.
- R5: With total_cnt nonzero, ratio is floor(emerg_cnt * 2^16 / total_cnt). When every counted cycle was an emergency, ratio is 0xFFFF.
- R6: migrate is 1 exactly when emerg_cnt/total_cnt is strictly greater than thresh/2^16, otherwise 0. With thresh = 0, one emergency cycle gives migrate = 1, and a window without emergencies gives migrate = 0.
- R7: A window closed with total_cnt = 0 reports ratio 0 and migrate 0. Its done pulse comes one cycle after the close edge.
- R8: For a nonempty window, done is high for exactly one cycle, 18 cycles after the clock edge that samples win_stop. ratio and migrate hold their value until the next done.
- R9: After reset the counts, ratio, migrate and done are all zero.
- R10: win_start is ignored unless the block is idle, and win_stop is ignored unless a window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_start | input | 1 | Opens a measurement window (idle only) |
| win_stop | input | 1 | Closes the open window |
| nom_code | input | SAMPLE_W | Nominal supply code, scaled to the limit at window open |
| thresh | input | FRAC_W | Decision threshold, unsigned Q0.16 |
| smp_vld | input | 1 | This cycle's sample bursts are valid |
| vdd_droop | input | SAMPLES*SAMPLE_W | Positive-rail droop magnitudes for this cycle |
| vss_rise | input | SAMPLES*SAMPLE_W | Ground-rail rise magnitudes for this cycle |
| emerg_cnt | output | CNT_W | Emergency cycles counted in the window |
| total_cnt | output | CNT_W | Valid cycles counted in the window |
| ratio | output | FRAC_W | Vulnerability fraction, unsigned Q0.16 |
| migrate | output | 1 | 1 = move the procedure, 0 = run locally |
| done | output | 1 | One-cycle pulse: ratio and migrate are valid |

## Verification
The checker assumes that win_start is never pulsed in the same cycle as a result is expected to stay stable. It also assumes that thresh does not change between window close and the done pulse, because the decision uses the live threshold value. The bench holds thresh and nom_code fixed from window open through done, except in the one test that changes nom_code on purpose inside a window. In that test it only checks that the limit captured at open stays in force. Window opens are issued only while idle, apart from the single test that pulses win_start inside an open window to show that the pulse is ignored.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_LOAD   = 2'd2,
        ST_DIV    = 2'd3
    } rvm_state_e;

    // Integer percentage of a code value, rounded down.
    function automatic logic [31:0] scale_pct(input logic [31:0] v, input logic [7:0] pct);
        return (v * 32'(pct)) / 32'd100;
    endfunction

endpackage

// File: rtl/rvm_rail_flag.sv
module rvm_rail_flag #(
    parameter int N = 15,
    parameter int W = 12
) (
    input  logic [N*W-1:0] samples,
    input  logic [W-1:0]   limit,
    output logic           over
);
    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            assign hit[i] = samples[i*W +: W] > limit;
        end
    endgenerate

    assign over = |hit;
endmodule

// File: rtl/rvm_frac_div.sv
module rvm_frac_div #(
    parameter int CNT_W  = 32,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  numer,
    input  logic [CNT_W-1:0]  denom,
    output logic              valid,
    output logic [FRAC_W-1:0] quot,
    output logic              rem_nz
);
    localparam int STEP_W = $clog2(FRAC_W);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(FRAC_W - 1);

    typedef struct packed {
        logic              run;
        logic              valid;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  rem;
        logic [FRAC_W-1:0] quo;
    } div_s;

    div_s q, d;
    logic [CNT_W:0]   rem_sh;
    logic [CNT_W-1:0] diff;
    logic             fits;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        rem_sh  = {q.rem, 1'b0};
        fits    = rem_sh >= {1'b0, denom};
        diff    = rem_sh[CNT_W-1:0] - denom;
        if (start) begin
            d.run  = 1'b1;
            d.step = '0;
            d.rem  = numer;
            d.quo  = '0;
        end else if (q.run) begin
            d.rem = fits ? diff : rem_sh[CNT_W-1:0];
            d.quo[LAST - q.step] = fits;
            d.step = q.step + 1'b1;
            if (q.step == LAST) begin
                d.run   = 1'b0;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid  = q.valid;
    assign quot   = q.quo;
    assign rem_nz = |q.rem;
endmodule

// File: rtl/rail_vuln_monitor.sv
module rail_vuln_monitor #(
    parameter int SAMPLES   = 15,
    parameter int SAMPLE_W  = 12,
    parameter int CNT_W     = 32,
    parameter int FRAC_W    = 16,
    parameter int LIMIT_PCT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_start,
    input  logic                        win_stop,
    input  logic [SAMPLE_W-1:0]         nom_code,
    input  logic [FRAC_W-1:0]           thresh,
    input  logic                        smp_vld,
    input  logic [SAMPLES*SAMPLE_W-1:0] vdd_droop,
    input  logic [SAMPLES*SAMPLE_W-1:0] vss_rise,
    output logic [CNT_W-1:0]            emerg_cnt,
    output logic [CNT_W-1:0]            total_cnt,
    output logic [FRAC_W-1:0]           ratio,
    output logic                        migrate,
    output logic                        done
);
    import rvm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        rvm_state_e          state;
        logic [SAMPLE_W-1:0] limit;
        logic [CNT_W-1:0]    emerg;
        logic [CNT_W-1:0]    total;
        logic [FRAC_W-1:0]   ratio;
        logic                migrate;
        logic                done;
    } mon_s;

    mon_s q, d;

    logic                over_vdd, over_vss, cyc_hit;
    logic [SAMPLE_W-1:0] lim_new;
    logic                div_start, div_valid, div_rem_nz;
    logic [FRAC_W-1:0]   div_quot;

    rvm_rail_flag #(.N(SAMPLES), .W(SAMPLE_W)) u_vdd (
        .samples(vdd_droop), .limit(q.limit), .over(over_vdd)
    );
    rvm_rail_flag #(.N(SAMPLES), .W(SAMPLE_W)) u_vss (
        .samples(vss_rise), .limit(q.limit), .over(over_vss)
    );

    assign cyc_hit   = over_vdd | over_vss;
    assign lim_new   = SAMPLE_W'(scale_pct(32'(nom_code), 8'(LIMIT_PCT)));
    assign div_start = (q.state == ST_LOAD) && (q.total != '0);

    rvm_frac_div #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (div_start),
        .numer  (q.emerg),
        .denom  (q.total),
        .valid  (div_valid),
        .quot   (div_quot),
        .rem_nz (div_rem_nz)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (win_start) begin
                    d.state = ST_ACTIVE;
                    d.limit = lim_new;
                    d.emerg = '0;
                    d.total = '0;
                end
            end
            ST_ACTIVE: begin
                if (smp_vld) begin
                    d.total = (q.total == CNT_MAX) ? q.total : q.total + 1'b1;
                    if (cyc_hit)
                        d.emerg = (q.emerg == CNT_MAX) ? q.emerg : q.emerg + 1'b1;
                end
                if (win_stop) d.state = ST_LOAD;
            end
            ST_LOAD: begin
                if (q.total == '0) begin
                    d.ratio   = '0;
                    d.migrate = 1'b0;
                    d.done    = 1'b1;
                    d.state   = ST_IDLE;
                end else begin
                    d.state = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_valid) begin
                    d.ratio   = div_quot;
                    d.migrate = (div_quot > thresh) || ((div_quot == thresh) && div_rem_nz);
                    d.done    = 1'b1;
                    d.state   = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign emerg_cnt = q.emerg;
    assign total_cnt = q.total;
    assign ratio     = q.ratio;
    assign migrate   = q.migrate;
    assign done      = q.done;
endmodule

// File: rtl/rvm_checker.sv
module rvm_checker #(
    parameter int CNT_W  = 32,
    parameter int FRAC_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_start,
    input logic              done,
    input logic [CNT_W-1:0]  emerg_cnt,
    input logic [CNT_W-1:0]  total_cnt,
    input logic [FRAC_W-1:0] ratio,
    input logic              migrate
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R8: result strobe lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: emergency cycles are a subset of counted cycles
    a_r3_emerg_le_total: assert property (@(posedge clk) disable iff (!rst_n)
        emerg_cnt <= total_cnt);

    // R3: the cycle count only grows inside a window
    a_r3_total_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        !win_start |=> total_cnt >= $past(total_cnt));

    // R4: a full counter stays full
    a_r4_total_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (total_cnt == TOP && !win_start) |=> total_cnt == TOP);

    // R7: an empty window reports zero and stays local
    a_r7_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && total_cnt == '0) |-> (ratio == '0 && !migrate));

    // R5: every counted cycle in emergency gives the top code
    a_r5_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && total_cnt != '0 && emerg_cnt == total_cnt) |-> (&ratio));

    // R6: a quiet window never asks to move
    a_r6_quiet_runs_local: assert property (@(posedge clk) disable iff (!rst_n)
        (done && emerg_cnt == '0) |-> !migrate);

    // R8: results change only together with the strobe
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ratio) && $stable(migrate)));
endmodule

bind rail_vuln_monitor rvm_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_start (win_start),
    .done      (done),
    .emerg_cnt (emerg_cnt),
    .total_cnt (total_cnt),
    .ratio     (ratio),
    .migrate   (migrate)
);

// File: tb/sim_rail_vuln_monitor.sv
module sim_rail_vuln_monitor;
    localparam int NS = 15;
    localparam int SW = 12;
    localparam int CW = 8;
    localparam int FW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            win_start = 1'b0;
    logic            win_stop = 1'b0;
    logic [SW-1:0]   nom_code = '0;
    logic [FW-1:0]   thresh = '0;
    logic            smp_vld = 1'b0;
    logic [NS*SW-1:0] vdd_droop = '0;
    logic [NS*SW-1:0] vss_rise = '0;
    logic [CW-1:0]   emerg_cnt, total_cnt;
    logic [FW-1:0]   ratio;
    logic            migrate, done;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rail_vuln_monitor #(.SAMPLES(NS), .SAMPLE_W(SW), .CNT_W(CW), .FRAC_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_stop(win_stop),
        .nom_code(nom_code), .thresh(thresh), .smp_vld(smp_vld),
        .vdd_droop(vdd_droop), .vss_rise(vss_rise),
        .emerg_cnt(emerg_cnt), .total_cnt(total_cnt), .ratio(ratio),
        .migrate(migrate), .done(done)
    );

    typedef struct packed {
        logic [11:0] nom;
        logic [15:0] thr;
        logic [9:0]  ncyc;
        logic [3:0]  per;
        logic        rail;
        logic [3:0]  pos;
        logic [7:0]  exp_e;
        logic [15:0] exp_ratio;
        logic        exp_mig;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{12'd1000, 16'd0,     10'd20, 4'd0, 1'b0, 4'd0,  8'd0,  16'd0,     1'b0},
        '{12'd1000, 16'd0,     10'd20, 4'd5, 1'b0, 4'd0,  8'd4,  16'd13107, 1'b1},
        '{12'd990,  16'd16384, 10'd16, 4'd4, 1'b1, 4'd14, 8'd4,  16'd16384, 1'b0},
        '{12'd990,  16'd16383, 10'd16, 4'd4, 1'b1, 4'd14, 8'd4,  16'd16384, 1'b1},
        '{12'd810,  16'd0,     10'd10, 4'd1, 1'b0, 4'd7,  8'd10, 16'd65535, 1'b1},
        '{12'd810,  16'd65535, 10'd10, 4'd1, 1'b1, 4'd3,  8'd10, 16'd65535, 1'b1},
        '{12'd1000, 16'd20000, 10'd12, 4'd3, 1'b1, 4'd9,  8'd4,  16'd21845, 1'b1},
        '{12'd500,  16'd30000, 10'd9,  4'd3, 1'b0, 4'd14, 8'd3,  16'd21845, 1'b0}
    };

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(input logic vld, input int vv, input int sv, input int pos);
        for (int k = 0; k < NS; k++) begin
            vdd_droop[k*SW +: SW] = 12'd1;
            vss_rise[k*SW +: SW]  = 12'd1;
        end
        vdd_droop[pos*SW +: SW] = vv[SW-1:0];
        vss_rise[pos*SW +: SW]  = sv[SW-1:0];
        smp_vld = vld;
        @(posedge clk); #1;
    endtask

    task automatic open_win(input logic [11:0] nom, input logic [15:0] thr);
        nom_code = nom;
        thresh = thr;
        win_start = 1'b1;
        @(posedge clk); #1;
        win_start = 1'b0;
    endtask

    task automatic close_win(output int lat);
        smp_vld = 1'b0;
        win_stop = 1'b1;
        @(posedge clk); #1;
        win_stop = 1'b0;
        lat = 0;
        do begin
            @(posedge clk); #1;
            lat++;
        end while (!done && lat < 100);
    endtask

    task automatic check_result(input string tag, input int lat, input int exp_lat,
                                input int e, input int t, input int r, input int m);
        chk({tag, " R8 latency"}, lat, exp_lat);
        chk({tag, " R3 emerg_cnt"}, emerg_cnt, e);
        chk({tag, " R3 total_cnt"}, total_cnt, t);
        chk({tag, " R5 ratio"}, ratio, r);
        chk({tag, " R6 migrate"}, migrate, m);
        @(posedge clk); #1;
        chk({tag, " R8 done one cycle"}, done, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        int lim;
        int dseen;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9: reset state
        chk("R9 emerg_cnt", emerg_cnt, 0);
        chk("R9 total_cnt", total_cnt, 0);
        chk("R9 ratio", ratio, 0);
        chk("R9 migrate", migrate, 0);
        chk("R9 done", done, 0);

        // Table-driven windows: R1 boundary (limit-valued samples), R5, R6
        for (int v = 0; v < 8; v++) begin
            lim = int'(VECS[v].nom) * 4 / 100;
            open_win(VECS[v].nom, VECS[v].thr);
            for (int i = 0; i < int'(VECS[v].ncyc); i++) begin
                if (VECS[v].per != 0 && (i % int'(VECS[v].per)) == 0) begin
                    if (VECS[v].rail) put(1'b1, lim, lim + 1, int'(VECS[v].pos));
                    else              put(1'b1, lim + 1, lim, int'(VECS[v].pos));
                end else begin
                    put(1'b1, lim, lim, int'(VECS[v].pos));
                end
            end
            close_win(lat);
            check_result($sformatf("R1 vec%0d", v), lat, 18, int'(VECS[v].exp_e),
                         int'(VECS[v].ncyc), int'(VECS[v].exp_ratio), int'(VECS[v].exp_mig));
        end

        // R7: empty window clears previous ratio
        open_win(12'd1000, 16'd0);
        close_win(lat);
        check_result("R7 empty", lat, 1, 0, 0, 0, 0);

        // R2: limit captured at open (1000 -> 40), later nom_code change ignored
        open_win(12'd1000, 16'd0);
        nom_code = 12'd100;
        for (int i = 0; i < 6; i++) put(1'b1, 30, 30, 5);
        put(1'b1, 41, 1, 2);
        close_win(lat);
        check_result("R2 latched", lat, 18, 1, 7, 9362, 1);

        // R3: invalid cycles are not counted even with large samples
        open_win(12'd1000, 16'd0);
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 0) put(1'b1, 40, 40, 0);
            else            put(1'b0, 200, 200, 0);
        end
        close_win(lat);
        check_result("R3 vld gate", lat, 18, 0, 4, 0, 0);

        // R10: stop while idle does nothing
        win_stop = 1'b1;
        @(posedge clk); #1;
        win_stop = 1'b0;
        dseen = 0;
        for (int i = 0; i < 25; i++) begin
            @(posedge clk); #1;
            if (done) dseen++;
        end
        chk("R10 stop idle no done", dseen, 0);
        chk("R10 stop idle ratio kept", ratio, 0);

        // R10: start inside an open window does not clear the counts
        open_win(12'd1000, 16'd0);
        for (int i = 0; i < 3; i++) put(1'b1, 41, 1, 0);
        win_start = 1'b1;
        put(1'b1, 41, 1, 0);
        win_start = 1'b0;
        for (int i = 0; i < 2; i++) put(1'b1, 1, 41, 0);
        close_win(lat);
        check_result("R10 start ignored", lat, 18, 6, 6, 65535, 1);

        // R4: saturation of the cycle count (CNT_W = 8 here)
        open_win(12'd1000, 16'd0);
        for (int i = 0; i < 300; i++) begin
            if (i < 10) put(1'b1, 41, 1, 0);
            else        put(1'b1, 1, 1, 0);
        end
        close_win(lat);
        check_result("R4 total sat", lat, 18, 10, 255, 2570, 1);

        // R4: both counts saturate
        open_win(12'd1000, 16'd0);
        for (int i = 0; i < 300; i++) put(1'b1, 1, 41, 4);
        close_win(lat);
        check_result("R4 both sat", lat, 18, 255, 255, 65535, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule